// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This unit decides where program flow goes next for the conditional branches and skips of a small 8-bit RISC core. The issue stage presents one flow instruction at a time: its kind, the current program counter, the status register, a bit selector and a set/clear polarity, a signed 7-bit relative offset, two register operands, one I/O bit, and a flag that says whether the instruction after it is one word or two. One clock later the unit returns the program counter to fetch from, whether the condition held, and how many cycles the instruction occupies. Fetch, the register file and the ALU lie outside the unit.

A branch jumps relative to the word after itself when its condition holds. A skip steps over the next instruction when its condition holds, so it must know how long that instruction is. All program counter arithmetic wraps within a 512-word program space.

Top module: `branch_skip_unit`

## Requirements
- R1: After reset `resultValid`, `nextPc`, `cycleCount` and `taken` are 0. `resultValid` is 1 exactly in the cycle after a cycle with `issueValid` high. In any cycle after one without `issueValid`, `resultValid` is 0 and `nextPc`, `cycleCount` and `taken` keep their values.
- R2: Kind 0 (flag branch) is taken when bit `bitSel` of `statusReg` equals `wantSet`. The status layout is C=bit 0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7, so fixed conditions such as same-or-higher (bitSel 0, wantSet 0) and lower (bitSel 0, wantSet 1) are this kind.
- R3: Kind 1 (signed branch) is taken when (N xor V) equals `wantSet`: wantSet 0 gives greater-or-equal, wantSet 1 gives less-than. The S bit is not consulted.
- R4: A taken branch gives `nextPc` = `pcIn` + sign-extended `offset` + 1 and `cycleCount` = 2.
- R5: Any branch or skip whose condition fails gives `nextPc` = `pcIn` + 1, `cycleCount` = 1, `taken` = 0.
- R6: Kind 2 (skip on equal) is taken when `regLeft` equals `regRight`.
- R7: Kind 3 (skip on register bit) is taken when bit `bitSel` of `regLeft` equals `wantSet`.
- R8: Kind 4 (skip on I/O bit) is taken when `ioBit` equals `wantSet`.
- R9: A taken skip gives `nextPc` = `pcIn` + 2 with `cycleCount` = 2 when `nextTwoWord` is 0, and `pcIn` + 3 with `cycleCount` = 3 when it is 1.
- R10: Kinds 5, 6 and 7 are never taken and give `pcIn` + 1 and `cycleCount` = 1 whatever the other inputs are.
- R11: All program counter results are taken modulo 512, both forward past 511 and backward below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A flow instruction is presented this cycle |
| opKind | input | 3 | Instruction kind, 0 to 4 as in R2, R3, R6 to R8, others reserved |
| statusReg | input | 8 | Status register |
| bitSel | input | 3 | Bit selector for flag branch and register-bit skip |
| wantSet | input | 1 | 1 tests for set, 0 tests for clear |
| offset | input | 7 | Signed relative branch offset |
| regLeft | input | 8 | First register operand |
| regRight | input | 8 | Second register operand |
| ioBit | input | 1 | Tested I/O register bit |
| nextTwoWord | input | 1 | Following instruction is two words long |
| pcIn | input | 9 | Program counter of the flow instruction |
| resultValid | output | 1 | Results below belong to the previous cycle's issue |
| nextPc | output | 9 | Program counter to fetch from next |
| cycleCount | output | 2 | Cycles the instruction takes: 1, 2 or 3 |
| taken | output | 1 | The condition held |

## Verification
Every result is registered once, so each output answers the issue of the previous cycle: the bench drives an instruction on a falling edge, lets one rising edge load it, and compares all four outputs at the following falling edge. Instructions go back to back, so each comparison also confirms that the next issue replaced the old result, and after each sweep an idle cycle checks that `resultValid` drops while the other outputs hold. Sweeps cover every status value against every bit and polarity, every offset from several start addresses including both ends of the program space, and every register-bit pattern for the skips.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  // Status register bit positions the signed condition relies on.
  localparam int STAT_W = 8;
  localparam int BIT_N  = 2;
  localparam int BIT_V  = 3;

  // Flow instruction kinds; codes 5..7 are reserved and never redirect.
  typedef enum logic [2:0] {
    OP_FLAG_BR     = 3'd0,
    OP_SIGNED_BR   = 3'd1,
    OP_SKIP_EQ     = 3'd2,
    OP_SKIP_REGBIT = 3'd3,
    OP_SKIP_IOBIT  = 3'd4
  } flowOpT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       load;       // capture a new result this cycle
    logic       useTarget;  // take the relative branch target
    logic [1:0] stride;     // sequential advance 1, 2 or 3 words
    logic [1:0] cycles;     // cycle count of the instruction
    logic       taken;      // condition held
  } flowCtrlT;

endpackage

// File: rtl/bsu_control.sv
module bsu_control
  import bsu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic                issueValid,
  input  logic [2:0]          opKind,
  input  logic [STAT_W-1:0]   statusReg,
  input  logic [SEL_W-1:0]    bitSel,
  input  logic                wantSet,
  input  logic [DATA_W-1:0]   regLeft,
  input  logic [DATA_W-1:0]   regRight,
  input  logic                ioBit,
  input  logic                nextTwoWord,
  output flowCtrlT            ctrl
);

  logic condMet;
  logic isBranch;
  logic isSkip;
  logic signedLess;

  assign signedLess = statusReg[BIT_N] ^ statusReg[BIT_V];

  // Condition evaluation per instruction kind.
  always_comb begin
    condMet  = 1'b0;
    isBranch = 1'b0;
    isSkip   = 1'b0;
    case (opKind)
      OP_FLAG_BR: begin
        isBranch = 1'b1;
        condMet  = (statusReg[bitSel] == wantSet);
      end
      OP_SIGNED_BR: begin
        isBranch = 1'b1;
        condMet  = (signedLess == wantSet);
      end
      OP_SKIP_EQ: begin
        isSkip  = 1'b1;
        condMet = (regLeft == regRight);
      end
      OP_SKIP_REGBIT: begin
        isSkip  = 1'b1;
        condMet = (regLeft[bitSel] == wantSet);
      end
      OP_SKIP_IOBIT: begin
        isSkip  = 1'b1;
        condMet = (ioBit == wantSet);
      end
      default: begin
        condMet = 1'b0;
      end
    endcase
  end

  // Turn the decision into datapath strobes.
  always_comb begin
    ctrl.load      = issueValid;
    ctrl.useTarget = 1'b0;
    ctrl.stride    = 2'd1;
    ctrl.cycles    = 2'd1;
    ctrl.taken     = 1'b0;
    if (condMet && isBranch) begin
      ctrl.useTarget = 1'b1;
      ctrl.cycles    = 2'd2;
      ctrl.taken     = 1'b1;
    end else if (condMet && isSkip) begin
      ctrl.taken  = 1'b1;
      ctrl.stride = nextTwoWord ? 2'd3 : 2'd2;
      ctrl.cycles = nextTwoWord ? 2'd3 : 2'd2;
    end
  end

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int PC_W  = 9,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  flowCtrlT         ctrl,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [OFF_W-1:0] offset,
  output logic             resultValid,
  output logic [PC_W-1:0]  nextPc,
  output logic [1:0]       cycleCount,
  output logic             taken
);

  localparam int MAX_STRIDE = 3;

  logic [PC_W-1:0] offExt;
  logic [PC_W-1:0] branchTarget;
  logic [PC_W-1:0] stepPc [0:MAX_STRIDE];
  logic [PC_W-1:0] nextPcD;

  // Sign extension or truncation of the offset to the PC width.
  generate
    if (PC_W > OFF_W) begin : gExtend
      assign offExt = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
    end else begin : gTrunc
      assign offExt = offset[PC_W-1:0];
    end
  endgenerate

  // Sequential advance candidates, each wrapping in the PC width.
  generate
    for (genvar g = 0; g <= MAX_STRIDE; g++) begin : gStep
      assign stepPc[g] = pcIn + PC_W'(g);
    end
  endgenerate

  assign branchTarget = stepPc[1] + offExt;
  assign nextPcD      = ctrl.useTarget ? branchTarget : stepPc[ctrl.stride];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      nextPc      <= '0;
      cycleCount  <= '0;
      taken       <= 1'b0;
    end else begin
      resultValid <= ctrl.load;
      if (ctrl.load) begin
        nextPc     <= nextPcD;
        cycleCount <= ctrl.cycles;
        taken      <= ctrl.taken;
      end
    end
  end

endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
  import bsu_pkg::*;
#(
  parameter int PC_W   = 9,
  parameter int OFF_W  = 7,
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [2:0]        opKind,
  input  logic [STAT_W-1:0] statusReg,
  input  logic [SEL_W-1:0]  bitSel,
  input  logic              wantSet,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] regLeft,
  input  logic [DATA_W-1:0] regRight,
  input  logic              ioBit,
  input  logic              nextTwoWord,
  input  logic [PC_W-1:0]   pcIn,
  output logic              resultValid,
  output logic [PC_W-1:0]   nextPc,
  output logic [1:0]        cycleCount,
  output logic              taken
);

  flowCtrlT ctrl;

  bsu_control #(.DATA_W(DATA_W)) uControl (
    .issueValid (issueValid),
    .opKind     (opKind),
    .statusReg  (statusReg),
    .bitSel     (bitSel),
    .wantSet    (wantSet),
    .regLeft    (regLeft),
    .regRight   (regRight),
    .ioBit      (ioBit),
    .nextTwoWord(nextTwoWord),
    .ctrl       (ctrl)
  );

  bsu_datapath #(.PC_W(PC_W), .OFF_W(OFF_W)) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .pcIn       (pcIn),
    .offset     (offset),
    .resultValid(resultValid),
    .nextPc     (nextPc),
    .cycleCount (cycleCount),
    .taken      (taken)
  );

endmodule

// File: rtl/branch_skip_unit_chk.sv
module branch_skip_unit_chk #(
  parameter int PC_W = 9
) (
  input logic            clk,
  input logic            rstN,
  input logic            issueValid,
  input logic [2:0]      opKind,
  input logic [1:0]      nvBits,
  input logic            wantSet,
  input logic            nextTwoWord,
  input logic [PC_W-1:0] pcIn,
  input logic            resultValid,
  input logic [PC_W-1:0] nextPc,
  input logic [1:0]      cycleCount,
  input logic            taken
);

  AST_RESULT_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> resultValid); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> !resultValid && $stable(nextPc) && $stable(cycleCount) && $stable(taken)); // R1

  AST_BRANCH_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && (opKind <= 3'd1) |=> (taken ? (cycleCount == 2'd2) : (cycleCount == 2'd1))); // R4

  AST_SIGNED_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && (opKind == 3'd1) |=> (taken == (($past(nvBits[0]) ^ $past(nvBits[1])) == $past(wantSet)))); // R3

  AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && !taken |-> (cycleCount == 2'd1) && (nextPc == PC_W'($past(pcIn) + 1'b1))); // R5

  AST_LONG_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && (opKind >= 3'd2) && (opKind <= 3'd4) && nextTwoWord
      |=> !taken || ((cycleCount == 2'd3) && (nextPc == PC_W'($past(pcIn) + 2'd3)))); // R9

  AST_RESERVED_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && (opKind > 3'd4) |=> !taken); // R10

endmodule

// N is status bit 2 and V is status bit 3.
bind branch_skip_unit branch_skip_unit_chk #(.PC_W(PC_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .opKind     (opKind),
  .nvBits     (statusReg[3:2]),
  .wantSet    (wantSet),
  .nextTwoWord(nextTwoWord),
  .pcIn       (pcIn),
  .resultValid(resultValid),
  .nextPc     (nextPc),
  .cycleCount (cycleCount),
  .taken      (taken)
);

// File: tb/branch_skip_unit_test.sv
`timescale 1ns/1ps
module branch_skip_unit_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       issueValid;
  logic [2:0] opKind;
  logic [7:0] statusReg;
  logic [2:0] bitSel;
  logic       wantSet;
  logic [6:0] offset;
  logic [7:0] regLeft;
  logic [7:0] regRight;
  logic       ioBit;
  logic       nextTwoWord;
  logic [8:0] pcIn;
  logic       resultValid;
  logic [8:0] nextPc;
  logic [1:0] cycleCount;
  logic       taken;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  branch_skip_unit uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opKind(opKind),
    .statusReg(statusReg), .bitSel(bitSel), .wantSet(wantSet), .offset(offset),
    .regLeft(regLeft), .regRight(regRight), .ioBit(ioBit), .nextTwoWord(nextTwoWord),
    .pcIn(pcIn), .resultValid(resultValid), .nextPc(nextPc), .cycleCount(cycleCount),
    .taken(taken)
  );

  // Drive one issue on a falling edge, compare on the next falling edge.
  task automatic apply(input logic [2:0] op, input logic [7:0] st, input logic [2:0] sel,
                       input logic want, input logic [6:0] off, input logic [7:0] l,
                       input logic [7:0] r, input logic io, input logic two,
                       input logic [8:0] pc, input string tag);
    bit cond;
    int expPc;
    int expCyc;
    int offVal;
    issueValid = 1'b1; opKind = op; statusReg = st; bitSel = sel; wantSet = want;
    offset = off; regLeft = l; regRight = r; ioBit = io; nextTwoWord = two; pcIn = pc;
    case (op)
      3'd0: cond = (st[sel] == want);
      3'd1: cond = ((st[2] ^ st[3]) == want);
      3'd2: cond = (l == r);
      3'd3: cond = (l[sel] == want);
      3'd4: cond = (io == want);
      default: cond = 1'b0;
    endcase
    offVal = off[6] ? int'(off) - 128 : int'(off);
    if (!cond) begin
      expPc = int'(pc) + 1; expCyc = 1;
    end else if (op <= 3'd1) begin
      expPc = int'(pc) + offVal + 1; expCyc = 2;
    end else begin
      expPc = int'(pc) + (two ? 3 : 2); expCyc = two ? 3 : 2;
    end
    expPc = (expPc + 1024) % 512;
    @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (resultValid !== 1'b1 || nextPc !== 9'(expPc) || cycleCount !== 2'(expCyc) ||
        taken !== cond) begin
      nFails++;
      $display("FAIL %s op=%0d pc=%0d: got valid=%b pc=%0d cyc=%0d taken=%b, want valid=1 pc=%0d cyc=%0d taken=%b",
               tag, op, pc, resultValid, nextPc, cycleCount, taken, expPc, expCyc, cond);
    end
  endtask

  // One idle cycle: the result must drop its valid flag and hold its values.
  task automatic idleCheck();
    logic [8:0] pcHeld;
    logic [1:0] cycHeld;
    logic       tkHeld;
    pcHeld = nextPc; cycHeld = cycleCount; tkHeld = taken;
    issueValid = 1'b0;
    opKind = 3'd0; statusReg = 8'hFF; wantSet = 1'b1; pcIn = 9'd77;
    @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (resultValid !== 1'b0 || nextPc !== pcHeld || cycleCount !== cycHeld || taken !== tkHeld) begin
      nFails++;
      $display("FAIL R1 idle hold: got valid=%b pc=%0d cyc=%0d taken=%b, want valid=0 pc=%0d cyc=%0d taken=%b",
               resultValid, nextPc, cycleCount, taken, pcHeld, cycHeld, tkHeld);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stimulus
    rstN = 1'b0; issueValid = 1'b0; opKind = '0; statusReg = '0; bitSel = '0;
    wantSet = 1'b0; offset = '0; regLeft = '0; regRight = '0; ioBit = 1'b0;
    nextTwoWord = 1'b0; pcIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state.
    nChecks++;
    if (resultValid !== 1'b0 || nextPc !== 9'd0 || cycleCount !== 2'd0 || taken !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: got valid=%b pc=%0d cyc=%0d taken=%b, want 0 0 0 0",
               resultValid, nextPc, cycleCount, taken);
    end
    rstN = 1'b1;
    @(negedge clk);
    idleCheck();

    // R2: flag branch over every status, bit and polarity.
    for (int st = 0; st < 256; st++)
      for (int b = 0; b < 8; b++)
        for (int w = 0; w < 2; w++)
          apply(3'd0, 8'(st), 3'(b), 1'(w), 7'd9, 8'h00, 8'h00, 1'b0, 1'b0, 9'(st * 2 + b), "R2");
    idleCheck();

    // R3: signed branch; S bit is part of the swept status.
    for (int st = 0; st < 256; st++)
      for (int w = 0; w < 2; w++)
        apply(3'd1, 8'(st), 3'(st), 1'(w), 7'h7C, 8'h00, 8'h00, 1'b0, 1'b1, 9'(st + 200), "R3");
    idleCheck();

    // R4, R5, R11: every offset, taken and not taken, at both ends of the space.
    for (int o = 0; o < 128; o++) begin
      apply(3'd0, 8'h01, 3'd0, 1'b1, 7'(o), 8'h00, 8'h00, 1'b0, 1'b0, 9'd0,   "R4 R11");
      apply(3'd0, 8'h01, 3'd0, 1'b1, 7'(o), 8'h00, 8'h00, 1'b0, 1'b0, 9'd511, "R4 R11");
      apply(3'd0, 8'h01, 3'd0, 1'b1, 7'(o), 8'h00, 8'h00, 1'b0, 1'b0, 9'd60,  "R4");
      apply(3'd0, 8'h01, 3'd0, 1'b1, 7'(o), 8'h00, 8'h00, 1'b0, 1'b0, 9'd450, "R4 R11");
      apply(3'd0, 8'h01, 3'd0, 1'b0, 7'(o), 8'h00, 8'h00, 1'b0, 1'b1, 9'd511, "R5 R11");
      apply(3'd0, 8'h01, 3'd0, 1'b0, 7'(o), 8'h00, 8'h00, 1'b0, 1'b1, 9'(o),  "R5");
    end
    idleCheck();

    // R6, R9: equality skip against equal and unequal partners.
    for (int l = 0; l < 256; l++) begin
      apply(3'd2, 8'h00, 3'd0, 1'b0, 7'd0, 8'(l), 8'(l),         1'b0, 1'(l), 9'(l + 256), "R6 R9");
      apply(3'd2, 8'h00, 3'd0, 1'b0, 7'd0, 8'(l), 8'(l ^ 1),     1'b0, 1'(l), 9'(l),       "R6 R5");
      apply(3'd2, 8'h00, 3'd0, 1'b0, 7'd0, 8'(l), 8'(l ^ 8'h80), 1'b0, 1'b1, 9'(l),       "R6 R5");
      apply(3'd2, 8'h00, 3'd0, 1'b0, 7'd0, 8'(l), 8'(l),         1'b0, 1'(~l[0]), 9'(509 + (l % 3)), "R9 R11");
    end
    idleCheck();

    // R7, R9: register-bit skip over every value, bit and polarity.
    for (int l = 0; l < 256; l++)
      for (int b = 0; b < 8; b++)
        for (int w = 0; w < 2; w++)
          apply(3'd3, 8'h00, 3'(b), 1'(w), 7'd0, 8'(l), 8'h00, 1'b0, 1'(l >> 7), 9'(l * 2 + w), "R7 R9");
    idleCheck();

    // R8, R9, R11: I/O bit skip near the top of the space.
    for (int io = 0; io < 2; io++)
      for (int w = 0; w < 2; w++)
        for (int t = 0; t < 2; t++)
          for (int p = 508; p < 512; p++)
            apply(3'd4, 8'hFF, 3'd7, 1'(w), 7'd5, 8'hFF, 8'hFF, 1'(io), 1'(t), 9'(p), "R8 R9 R11");
    idleCheck();

    // R10: reserved kinds ignore every condition input.
    for (int op = 5; op < 8; op++)
      for (int st = 0; st < 256; st++)
        apply(3'(op), 8'(st), 3'(st), 1'(st >> 3), 7'(st), 8'(st), 8'(st), 1'(st >> 1), 1'(st),
              9'(st + 255), "R10");
    idleCheck();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule